// File: doc/BRIEF.md
# Burst Patch Download Controller

This block manages the download of a firmware patch image into a local patch memory. A host first sends a start command that carries a 7-bit burst target address. The controller then switches from its boot mode to patch mode. In patch mode, every data byte written to that burst address on the I2C target bus goes to the next patch memory location. After each byte the write pointer advances by one. The pointer keeps its value across bus stop conditions, so the host may send the image as one transaction or split it into several. A complete command moves the controller on to application mode. An end command abandons the download and rewinds the pointer.

The I2C bit layer is outside this block. It sees the bus as byte-level events: an address phase, data bytes and a stop. The controller always answers on its fundamental address, which is a fixed base combined with two static strap inputs. It answers the burst address only while a download is active, and only for writes. Several controllers can therefore share one burst address and receive the same image at the same time.

The current mode is reported as four ASCII characters. Each command is answered one cycle later with a 2-bit status code.

Top module: `patch_burst_loader`

## Requirements
- R1: After reset, modeCode reads 0x424F4F54 ('BOOT'), writePtr is 0, overflow is 0 and memWe is low.
- R2: modeCode shows the mode as ASCII, with the first character in bits 31:24: boot is 0x424F4F54, patch is 0x50544348 ('PTCH') and application is 0x41505020 ('APP ').
- R3: A command is presented with cmdValid for one cycle. cmdCode 1 means start, 2 means complete and 3 means end. In the following cycle rspValid is high for exactly one cycle and rspStatus holds the result: 0 for success, 1 for a command not allowed in the current mode, 2 for cmdCode 0 (unknown). A rejected command changes nothing.
- R4: Start is accepted in boot or patch mode. It stores cmdAddr as the burst address, sets writePtr to 0, clears overflow and enters patch mode. In application mode it returns status 1.
- R5: A start whose cmdAddr equals the fundamental address returns status 3 and changes nothing.
- R6: The fundamental address is 0x20 OR cfgAddrSel. An address phase (busAddrValid) that carries it is acknowledged in every mode: ackValid and addrAck are high in the next cycle.
- R7: An address phase that carries the burst address is acknowledged only in patch mode and only for a write (busRnw = 0). Any other address phase gives ackValid high with addrAck low in the next cycle.
- R8: A data byte inside an acknowledged burst write transaction, received while in patch mode and with writePtr below DEPTH, gives memWe high for one cycle in the next cycle, with memAddr equal to the old pointer and memData equal to the byte. writePtr then increments by one.
- R9: A stop condition followed by a new burst address phase does not change writePtr. Writing continues at the next location.
- R10: Complete is accepted only in patch mode, where it moves to application mode and leaves writePtr unchanged. In boot or application mode it returns status 1.
- R11: End is accepted in boot or patch mode. It moves to boot mode, sets writePtr to 0 and clears overflow. In application mode it returns status 1.
- R12: The following cause no memory write and leave writePtr unchanged: data bytes outside patch mode, data bytes in a transaction to the fundamental or an unmatched address, and data bytes in a burst read transaction.
- R13: When writePtr equals DEPTH it holds there. A further burst byte gives no write and sets overflow, which stays set until an accepted start or end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgAddrSel | input | 2 | Static strap bits ORed into the fundamental address |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 2 | Command: 1 start, 2 complete, 3 end |
| cmdAddr | input | 7 | Burst address carried by a start command |
| rspValid | output | 1 | Command response strobe |
| rspStatus | output | 2 | Command result code |
| modeCode | output | 32 | Mode as four ASCII characters |
| busAddrValid | input | 1 | Address phase event from the bus layer |
| busAddr | input | 7 | Target address of the address phase |
| busRnw | input | 1 | Read (1) or write (0) for the address phase |
| busDataValid | input | 1 | Received data byte event |
| busData | input | 8 | Received data byte |
| busStop | input | 1 | Stop condition event |
| ackValid | output | 1 | Address decision strobe |
| addrAck | output | 1 | Address acknowledged |
| memWe | output | 1 | Patch memory write enable |
| memAddr | output | $clog2(DEPTH) | Patch memory write address |
| memData | output | 8 | Patch memory write data |
| writePtr | output | $clog2(DEPTH)+1 | Current write pointer |
| overflow | output | 1 | A byte was dropped because memory was full |

## Verification
The assertions check the following on every cycle:
- each command gets exactly one response;
- the mode is always legal, and application mode is reached only through an accepted complete command;
- the pointer stays within DEPTH, steps by exactly one per accepted byte and is otherwise stable;
- overflow stays set until cleared;
- no memory write happens outside patch mode.

Only the bench scenarios can show the end-to-end effects:
- the burst address loaded by one command steers bytes that arrive many cycles later;
- the pointer carries across stop conditions;
- status codes come out correct for each mode and command pairing;
- address rejection works for reads and foreign addresses.

// File: rtl/patch_loader_pkg.sv
package patch_loader_pkg;

  typedef enum logic [1:0] {
    MODE_BOOT  = 2'd0,
    MODE_PATCH = 2'd1,
    MODE_APP   = 2'd2
  } loaderMode_e;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_START    = 2'd1,
    CMD_COMPLETE = 2'd2,
    CMD_END      = 2'd3
  } loaderCmd_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FUND  = 2'd1,
    TGT_BURST = 2'd2
  } busTarget_e;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_BADMODE = 2'd1;
  localparam logic [1:0] ST_UNKNOWN = 2'd2;
  localparam logic [1:0] ST_BADADDR = 2'd3;

  localparam logic [6:0] FUND_BASE = 7'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBurst;
    logic ptrClear;
    logic writeByte;
  } dpCtrl_t;

  function automatic logic [31:0] modeAscii(loaderMode_e m);
    case (m)
      MODE_PATCH: modeAscii = {8'h50, 8'h54, 8'h43, 8'h48};
      MODE_APP:   modeAscii = {8'h41, 8'h50, 8'h50, 8'h20};
      default:    modeAscii = {8'h42, 8'h4F, 8'h4F, 8'h54};
    endcase
  endfunction

endpackage

// File: rtl/patch_loader_ctrl.sv
module patch_loader_ctrl
  import patch_loader_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  fundAddr,
  input  logic [6:0]  burstAddr,
  input  logic        cmdValid,
  input  logic [1:0]  cmdCode,
  input  logic [6:0]  cmdAddr,
  input  logic        busAddrValid,
  input  logic [6:0]  busAddr,
  input  logic        busRnw,
  input  logic        busDataValid,
  input  logic        busStop,
  output loaderMode_e mode,
  output dpCtrl_t     dpCtrl,
  output logic        rspValid,
  output logic [1:0]  rspStatus,
  output logic        ackValid,
  output logic        addrAck
);

  busTarget_e  target;
  loaderMode_e nextMode;
  logic [1:0]  cmdStatus;
  logic        cmdLoad;
  logic        cmdClear;
  busTarget_e  addrTarget;

  // command decode
  always_comb begin
    nextMode  = mode;
    cmdStatus = ST_OK;
    cmdLoad   = 1'b0;
    cmdClear  = 1'b0;
    if (cmdValid) begin
      case (loaderCmd_e'(cmdCode))
        CMD_START: begin
          if (mode == MODE_APP) begin
            cmdStatus = ST_BADMODE;
          end else if (cmdAddr == fundAddr) begin
            cmdStatus = ST_BADADDR;
          end else begin
            nextMode = MODE_PATCH;
            cmdLoad  = 1'b1;
            cmdClear = 1'b1;
          end
        end
        CMD_COMPLETE: begin
          if (mode == MODE_PATCH) nextMode = MODE_APP;
          else                    cmdStatus = ST_BADMODE;
        end
        CMD_END: begin
          if (mode == MODE_APP) begin
            cmdStatus = ST_BADMODE;
          end else begin
            nextMode = MODE_BOOT;
            cmdClear = 1'b1;
          end
        end
        default: cmdStatus = ST_UNKNOWN;
      endcase
    end
  end

  // address match for the address phase
  always_comb begin
    if (busAddr == fundAddr)
      addrTarget = TGT_FUND;
    else if (mode == MODE_PATCH && !busRnw && busAddr == burstAddr)
      addrTarget = TGT_BURST;
    else
      addrTarget = TGT_NONE;
  end

  always_comb begin
    dpCtrl.loadBurst = cmdLoad;
    dpCtrl.ptrClear  = cmdClear;
    dpCtrl.writeByte = busDataValid && target == TGT_BURST && mode == MODE_PATCH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MODE_BOOT;
      target    <= TGT_NONE;
      rspValid  <= 1'b0;
      rspStatus <= ST_OK;
      ackValid  <= 1'b0;
      addrAck   <= 1'b0;
    end else begin
      mode     <= nextMode;
      rspValid <= cmdValid;
      if (cmdValid) rspStatus <= cmdStatus;
      ackValid <= busAddrValid;
      addrAck  <= busAddrValid && addrTarget != TGT_NONE;
      if (busStop)           target <= TGT_NONE;
      else if (busAddrValid) target <= addrTarget;
    end
  end

  a_r3_one_response : assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> rspValid);
  a_r3_no_spurious_rsp : assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |=> !rspValid);
  a_r2_mode_legal : assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_BOOT || mode == MODE_PATCH || mode == MODE_APP);
  a_r10_app_entry : assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_APP && !(cmdValid && cmdCode == 2'd2)) |=> mode != MODE_APP);
  a_r7_burst_gated : assert property (@(posedge clk) disable iff (!rst_n)
    (busAddrValid && busAddr != fundAddr && mode != MODE_PATCH) |=> !addrAck);
  a_r6_fund_acked : assert property (@(posedge clk) disable iff (!rst_n)
    (busAddrValid && busAddr == fundAddr) |=> (ackValid && addrAck));

endmodule

// File: rtl/patch_loader_dp.sv
module patch_loader_dp
  import patch_loader_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PTR_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtrl_t          dpCtrl,
  input  logic [6:0]       cmdAddr,
  input  logic [7:0]       busData,
  output logic [6:0]       burstAddr,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [7:0]       memData,
  output logic [PTR_W-1:0] writePtr,
  output logic             overflow
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH);

  logic roomLeft;
  assign roomLeft = writePtr < PTR_END;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burstAddr <= '0;
      memWe     <= 1'b0;
      memAddr   <= '0;
      memData   <= '0;
      writePtr  <= '0;
      overflow  <= 1'b0;
    end else begin
      memWe <= 1'b0;
      if (dpCtrl.loadBurst) burstAddr <= cmdAddr;
      if (dpCtrl.ptrClear) begin
        writePtr <= '0;
        overflow <= 1'b0;
      end else if (dpCtrl.writeByte) begin
        if (roomLeft) begin
          memWe    <= 1'b1;
          memAddr  <= writePtr[AW-1:0];
          memData  <= busData;
          writePtr <= writePtr + 1'b1;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end

  a_r8_ptr_step : assert property (@(posedge clk) disable iff (!rst_n)
    (dpCtrl.writeByte && !dpCtrl.ptrClear && writePtr < PTR_END)
      |=> (memWe && writePtr == $past(writePtr) + 1'b1));
  a_r13_ptr_bound : assert property (@(posedge clk) disable iff (!rst_n)
    writePtr <= PTR_END);
  a_r13_ovf_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !dpCtrl.ptrClear) |=> overflow);
  a_r12_ptr_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (!dpCtrl.writeByte && !dpCtrl.ptrClear) |=> ($stable(writePtr) && !memWe));
  a_r11_clear : assert property (@(posedge clk) disable iff (!rst_n)
    dpCtrl.ptrClear |=> (writePtr == '0 && !overflow));

endmodule

// File: rtl/patch_burst_loader.sv
module patch_burst_loader
  import patch_loader_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PTR_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfgAddrSel,
  input  logic             cmdValid,
  input  logic [1:0]       cmdCode,
  input  logic [6:0]       cmdAddr,
  output logic             rspValid,
  output logic [1:0]       rspStatus,
  output logic [31:0]      modeCode,
  input  logic             busAddrValid,
  input  logic [6:0]       busAddr,
  input  logic             busRnw,
  input  logic             busDataValid,
  input  logic [7:0]       busData,
  input  logic             busStop,
  output logic             ackValid,
  output logic             addrAck,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [7:0]       memData,
  output logic [PTR_W-1:0] writePtr,
  output logic             overflow
);

  loaderMode_e mode;
  dpCtrl_t     dpCtrl;
  logic [6:0]  burstAddr;
  logic [6:0]  fundAddr;

  assign fundAddr = FUND_BASE | {5'd0, cfgAddrSel};
  assign modeCode = modeAscii(mode);

  patch_loader_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fundAddr     (fundAddr),
    .burstAddr    (burstAddr),
    .cmdValid     (cmdValid),
    .cmdCode      (cmdCode),
    .cmdAddr      (cmdAddr),
    .busAddrValid (busAddrValid),
    .busAddr      (busAddr),
    .busRnw       (busRnw),
    .busDataValid (busDataValid),
    .busStop      (busStop),
    .mode         (mode),
    .dpCtrl       (dpCtrl),
    .rspValid     (rspValid),
    .rspStatus    (rspStatus),
    .ackValid     (ackValid),
    .addrAck      (addrAck)
  );

  patch_loader_dp #(.DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dpCtrl    (dpCtrl),
    .cmdAddr   (cmdAddr),
    .busData   (busData),
    .burstAddr (burstAddr),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData),
    .writePtr  (writePtr),
    .overflow  (overflow)
  );

  a_r12_write_in_patch : assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> $past(mode == MODE_PATCH));

endmodule

// File: tb/patch_burst_loader_test.sv
module patch_burst_loader_test;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int PTR_W = AW + 1;
  localparam logic [31:0] A_BOOT  = 32'h424F4F54;
  localparam logic [31:0] A_PATCH = 32'h50544348;
  localparam logic [31:0] A_APP   = 32'h41505020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfgAddrSel = 2'd2;
  logic cmdValid = 1'b0;
  logic [1:0] cmdCode = '0;
  logic [6:0] cmdAddr = '0;
  logic rspValid;
  logic [1:0] rspStatus;
  logic [31:0] modeCode;
  logic busAddrValid = 1'b0;
  logic [6:0] busAddr = '0;
  logic busRnw = 1'b0;
  logic busDataValid = 1'b0;
  logic [7:0] busData = '0;
  logic busStop = 1'b0;
  logic ackValid, addrAck, memWe, overflow;
  logic [AW-1:0] memAddr;
  logic [7:0] memData;
  logic [PTR_W-1:0] writePtr;

  always #2 clk = ~clk;

  patch_burst_loader #(.DEPTH(DEPTH)) uut (.*);

  int nChecks = 0;
  int nFails = 0;

  // reference model state: 0 boot, 1 patch, 2 app
  int expMode = 0;
  int expPtr = 0;
  bit expOvf = 0;
  logic [6:0] expBurst = '0;
  bit expSelBurst = 0;
  logic [6:0] fund;

  function automatic logic [31:0] expAscii(int m);
    return (m == 1) ? A_PATCH : (m == 2) ? A_APP : A_BOOT;
  endfunction

  function automatic int expStatus(int code, int m, logic [6:0] a, logic [6:0] f);
    case (code)
      1: return (m == 2) ? 1 : (a == f) ? 3 : 0;
      2: return (m == 1) ? 0 : 1;
      3: return (m == 2) ? 1 : 0;
      default: return 2;
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic checkState(string req);
    check(modeCode == expAscii(expMode), {req, " mode"}, modeCode, expAscii(expMode));
    check(writePtr == PTR_W'(expPtr), {req, " ptr"}, writePtr, expPtr);
    check(overflow == expOvf, {req, " ovf"}, overflow, expOvf);
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
    expMode = 0; expPtr = 0; expOvf = 0; expBurst = '0; expSelBurst = 0;
    // R1: reset state
    checkState("R1");
    check(memWe == 1'b0, "R1 memWe", memWe, 0);
  endtask

  task automatic sendStop();
    @(negedge clk); busStop = 1'b1;
    @(posedge clk); #1; busStop = 1'b0;
    expSelBurst = 0;
    // R9: stop leaves pointer alone
    check(writePtr == PTR_W'(expPtr), "R9 ptr after stop", writePtr, expPtr);
  endtask

  task automatic doCmd(int code, logic [6:0] a);
    int st;
    sendStop();
    st = expStatus(code, expMode, a, fund);
    @(negedge clk); cmdValid = 1'b1; cmdCode = 2'(code); cmdAddr = a;
    @(posedge clk); #1; cmdValid = 1'b0;
    if (st == 0) begin
      if (code == 1) begin expMode = 1; expPtr = 0; expOvf = 0; expBurst = a; end
      if (code == 2) expMode = 2;
      if (code == 3) begin expMode = 0; expPtr = 0; expOvf = 0; end
    end
    // R3 R4 R5 R10 R11: status and effect
    check(rspValid == 1'b1, "R3 rspValid", rspValid, 1);
    check(rspStatus == 2'(st), "R3 R4 R5 R10 R11 status", rspStatus, st);
    checkState("R2 R4 R10 R11 after cmd");
    @(posedge clk); #1;
    check(rspValid == 1'b0, "R3 single rsp", rspValid, 0);
  endtask

  task automatic sendAddr(logic [6:0] a, bit rnw);
    bit expAck;
    bit isBurst;
    isBurst = (a != fund) && expMode == 1 && !rnw && a == expBurst;
    expAck = (a == fund) || isBurst;
    @(negedge clk); busAddrValid = 1'b1; busAddr = a; busRnw = rnw;
    @(posedge clk); #1; busAddrValid = 1'b0;
    expSelBurst = isBurst;
    // R6 R7: address acknowledge
    check(ackValid == 1'b1, "R6 R7 ackValid", ackValid, 1);
    check(addrAck == expAck, "R6 R7 addrAck", addrAck, expAck);
  endtask

  task automatic sendByte(logic [7:0] b);
    bit expWe;
    int oldPtr;
    oldPtr = expPtr;
    expWe = 0;
    if (expSelBurst && expMode == 1) begin
      if (expPtr < DEPTH) begin expWe = 1; expPtr++; end
      else expOvf = 1;
    end
    @(negedge clk); busDataValid = 1'b1; busData = b;
    @(posedge clk); #1; busDataValid = 1'b0;
    // R8 R12 R13: write or no write
    check(memWe == expWe, "R8 R12 R13 memWe", memWe, expWe);
    if (expWe) begin
      check(memAddr == AW'(oldPtr), "R8 memAddr", memAddr, oldPtr);
      check(memData == b, "R8 memData", memData, b);
    end
    checkState("R8 R12 R13 after byte");
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    fund = 7'h20 | {5'd0, cfgAddrSel};
    void'($urandom(32'h5EED1234));
    doReset();
    // R10: complete in boot rejected; R3 unknown code
    doCmd(2, 7'h00);
    doCmd(0, 7'h00);
    // R5: start with fundamental address
    doCmd(1, fund);
    // R12: burst address in boot is not acked and not written
    sendAddr(7'h50, 0);
    sendByte(8'h11);
    // R4: valid start
    doCmd(1, 7'h50);
    sendAddr(7'h50, 0);
    for (int i = 0; i < 5; i++) sendByte(8'(8'hA0 + i));
    // R9: split transaction continues
    sendStop();
    sendAddr(7'h50, 0);
    for (int i = 0; i < 3; i++) sendByte(8'(8'hB0 + i));
    // R7 R12: burst read and fundamental address transactions write nothing
    sendStop();
    sendAddr(7'h50, 1);
    sendByte(8'h22);
    sendStop();
    sendAddr(fund, 0);
    sendByte(8'h33);
    sendStop();
    sendAddr(7'h51, 0);
    sendByte(8'h44);
    // R13: fill and overflow
    sendStop();
    sendAddr(7'h50, 0);
    for (int i = 0; i < DEPTH; i++) sendByte(8'($urandom));
    check(overflow == 1'b1, "R13 overflow set", overflow, 1);
    // R4: re-start clears pointer and overflow
    doCmd(1, 7'h3C);
    sendAddr(7'h3C, 0);
    sendByte(8'h5A);
    // R10: complete
    doCmd(2, 7'h00);
    sendAddr(7'h3C, 0);
    sendByte(8'h66);
    doCmd(1, 7'h3C);
    doCmd(3, 7'h00);
    doReset();
    // R11: end in boot is accepted
    doCmd(3, 7'h00);

    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [6:0] a;
      r = int'($urandom % 16);
      a = ($urandom % 3 == 0) ? fund : ($urandom % 2 == 0) ? expBurst : 7'($urandom);
      if (expMode == 2 && $urandom % 4 == 0) doReset();
      else if (r == 0) doCmd(1, ($urandom % 8 == 0) ? fund : 7'($urandom));
      else if (r == 1) begin if ($urandom % 3 == 0) doCmd(2, 7'h00); end
      else if (r == 2) doCmd(3, 7'h00);
      else if (r == 3) doCmd(0, 7'h00);
      else if (r == 4) sendStop();
      else if (r <= 6) sendAddr(a, ($urandom % 4 == 0));
      else sendByte(8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule